// File: doc/BRIEF.md
# Soft-Start and Light-Load Peak-Current Setpoint

This block produces the digital peak-current setpoint that a current-mode switching controller applies in each switching cycle. It takes a sampled control code from the feedback path and maps it onto a current range. The range runs from a light-load floor up to the full drain current limit. A ceiling that climbs in discrete steps after every start or restart then caps the result. The capped value is latched at the start of each switching cycle, so the setpoint never changes in the middle of a pulse.

At light load the control code falls to a lower threshold. The setpoint then stops shrinking and is held at the floor. Once the code is below that threshold, the block raises a skip flag so that the switching stage omits the cycle. As a result, a lighter load gives fewer pulses rather than smaller ones. A soft-start request restarts the ceiling ramp from zero. The soft-start flag stays high until the last step of the ramp has been reached.

Top module: `soft_start_pfm_setpoint`

## Requirements
- R1: While reset is asserted, `setpoint` is 0 and `pfm_skip` is 0. `ss_active` is 1, and the ceiling ramp starts from step 0 when reset is released.
- R2: The ceiling rises through `SS_STEPS` equal steps. Step k is reached k·`STEP_TICKS` clock edges after the ramp starts, and its ceiling is floor(`FULL_LIMIT`·k/`SS_STEPS`). After the last step the ceiling stays at `FULL_LIMIT`.
- R3: A clock edge with `ss_req` high restarts the ramp at step 0 with a ceiling of 0, whatever the current step.
- R4: `ss_active` is 1 exactly while the ramp step is below `SS_STEPS`. Once low, it stays low until the next `ss_req`.
- R5: A control code at or below `PFM_CODE` maps to the floor value `FLOOR_LIMIT`.
- R6: A control code at or above `FULL_CODE` maps to `FULL_LIMIT`.
- R7: A code strictly between the two thresholds maps to `FLOOR_LIMIT` + floor((code − `PFM_CODE`)·(`FULL_LIMIT` − `FLOOR_LIMIT`)/(`FULL_CODE` − `PFM_CODE`)).
- R8: On a clock edge with `cycle_start` high, `setpoint` takes the smaller of the mapped value and the ceiling in force before that edge. On every other edge it holds its value.
- R9: On a clock edge with `cycle_start` high, `pfm_skip` takes the value (code < `PFM_CODE`). It therefore clears at the first cycle start after the code rises back to the threshold. On other edges it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ss_req | input | 1 | Restart the soft-start ramp (start attempt or restart after a fault) |
| cycle_start | input | 1 | Strobe marking the start of a switching cycle |
| ctrl_code | input | CODE_W | Sampled control code from the feedback path |
| setpoint | output | SET_W | Peak-current setpoint for the current cycle |
| pfm_skip | output | 1 | Skip the current switching cycle (light load) |
| ss_active | output | 1 | Soft-start ramp still in progress |

## Verification
The properties assume that the parameters are ordered, with `FLOOR_LIMIT` ≤ `FULL_LIMIT` and `PFM_CODE` < `FULL_CODE`. They also assume that `ss_req` and `cycle_start` are synchronous single-cycle levels, and that `ctrl_code` only needs to be valid on edges where `cycle_start` is high. The stimulus drives every input half a period away from the active edge. It uses thresholds that meet the ordering, spreads random codes over the whole code range, and adds directed codes exactly at, just below and just above each threshold. The soft-start requests are rare, so that complete ramps run to the end, and a directed restart falls in the middle of a ramp.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

  typedef enum logic [0:0] {
    SS_RAMP = 1'b0,
    SS_DONE = 1'b1
  } ss_phase_e;

endpackage

// File: rtl/ssp_ramp.sv
module ssp_ramp #(
  parameter int unsigned SET_W      = 8,
  parameter int unsigned FULL_LIMIT = 240,
  parameter int unsigned SS_STEPS   = 8,
  parameter int unsigned STEP_TICKS = 200000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  output logic [SET_W-1:0] ceil_o,
  output logic             active_o
);
  import ssp_pkg::*;

  localparam int unsigned STEP_W   = $clog2(SS_STEPS + 1);
  localparam int unsigned TICK_W   = $clog2(STEP_TICKS);
  localparam int unsigned TAB_N    = 1 << STEP_W;
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(STEP_TICKS - 1);
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(SS_STEPS - 1);

  ss_phase_e         phase_q, phase_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [TICK_W-1:0] tick_q, tick_d;
  logic [SET_W-1:0]  ceil_tab [TAB_N];

  // one ceiling value per step; indices past the last step stay at the limit
  for (genvar k = 0; k < TAB_N; k++) begin : g_ceil
    if (k >= SS_STEPS) begin : g_top
      assign ceil_tab[k] = SET_W'(FULL_LIMIT);
    end else begin : g_step
      assign ceil_tab[k] = SET_W'((FULL_LIMIT * k) / SS_STEPS);
    end
  end

  always_comb begin
    phase_d = phase_q;
    step_d  = step_q;
    tick_d  = tick_q;
    if (restart) begin
      phase_d = SS_RAMP;
      step_d  = '0;
      tick_d  = '0;
    end else if (phase_q == SS_RAMP) begin
      if (tick_q == TICK_LAST) begin
        tick_d = '0;
        step_d = step_q + STEP_W'(1);
        if (step_q == STEP_LAST) begin
          phase_d = SS_DONE;
        end
      end else begin
        tick_d = tick_q + TICK_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= SS_RAMP;
      step_q  <= '0;
      tick_q  <= '0;
    end else begin
      phase_q <= phase_d;
      step_q  <= step_d;
      tick_q  <= tick_d;
    end
  end

  assign ceil_o   = ceil_tab[step_q];
  assign active_o = (phase_q == SS_RAMP);

endmodule

// File: rtl/ssp_map.sv
module ssp_map #(
  parameter int unsigned CODE_W      = 8,
  parameter int unsigned SET_W       = 8,
  parameter int unsigned FLOOR_LIMIT = 40,
  parameter int unsigned FULL_LIMIT  = 240,
  parameter int unsigned PFM_CODE    = 64,
  parameter int unsigned FULL_CODE   = 224
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [SET_W-1:0]  target_o,
  output logic              below_o
);
  localparam int unsigned PROD_W = CODE_W + SET_W;
  localparam int unsigned RISE   = FULL_LIMIT - FLOOR_LIMIT;
  localparam int unsigned SPAN   = FULL_CODE - PFM_CODE;

  logic [CODE_W-1:0] offset;
  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] quot;

  always_comb begin
    offset = code_i - CODE_W'(PFM_CODE);
    prod   = PROD_W'(offset) * PROD_W'(RISE);
    quot   = prod / PROD_W'(SPAN);
    if (code_i <= CODE_W'(PFM_CODE)) begin
      target_o = SET_W'(FLOOR_LIMIT);
    end else if (code_i >= CODE_W'(FULL_CODE)) begin
      target_o = SET_W'(FULL_LIMIT);
    end else begin
      target_o = SET_W'(FLOOR_LIMIT) + SET_W'(quot);
    end
    below_o = (code_i < CODE_W'(PFM_CODE));
  end

endmodule

// File: rtl/ssp_apply.sv
module ssp_apply #(
  parameter int unsigned SET_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cycle_start,
  input  logic [SET_W-1:0] target_i,
  input  logic [SET_W-1:0] ceil_i,
  input  logic             below_i,
  output logic [SET_W-1:0] setpoint_o,
  output logic             skip_o
);
  logic [SET_W-1:0] sp_q, sp_d;
  logic             skip_q, skip_d;

  always_comb begin
    sp_d   = (target_i < ceil_i) ? target_i : ceil_i;
    skip_d = below_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q   <= '0;
      skip_q <= 1'b0;
    end else if (cycle_start) begin
      sp_q   <= sp_d;
      skip_q <= skip_d;
    end
  end

  assign setpoint_o = sp_q;
  assign skip_o     = skip_q;

endmodule

// File: rtl/soft_start_pfm_setpoint.sv
module soft_start_pfm_setpoint #(
  parameter int unsigned CODE_W      = 8,
  parameter int unsigned SET_W       = 8,
  parameter int unsigned FLOOR_LIMIT = 40,
  parameter int unsigned FULL_LIMIT  = 240,
  parameter int unsigned PFM_CODE    = 64,
  parameter int unsigned FULL_CODE   = 224,
  parameter int unsigned SS_STEPS    = 8,
  parameter int unsigned STEP_TICKS  = 200000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ss_req,
  input  logic              cycle_start,
  input  logic [CODE_W-1:0] ctrl_code,
  output logic [SET_W-1:0]  setpoint,
  output logic              pfm_skip,
  output logic              ss_active
);
  logic [SET_W-1:0] ceil_w;
  logic [SET_W-1:0] target_w;
  logic             below_w;

  ssp_ramp #(
    .SET_W(SET_W), .FULL_LIMIT(FULL_LIMIT),
    .SS_STEPS(SS_STEPS), .STEP_TICKS(STEP_TICKS)
  ) u_ramp (
    .clk(clk), .rst_n(rst_n), .restart(ss_req),
    .ceil_o(ceil_w), .active_o(ss_active)
  );

  ssp_map #(
    .CODE_W(CODE_W), .SET_W(SET_W), .FLOOR_LIMIT(FLOOR_LIMIT),
    .FULL_LIMIT(FULL_LIMIT), .PFM_CODE(PFM_CODE), .FULL_CODE(FULL_CODE)
  ) u_map (
    .code_i(ctrl_code), .target_o(target_w), .below_o(below_w)
  );

  ssp_apply #(.SET_W(SET_W)) u_apply (
    .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start),
    .target_i(target_w), .ceil_i(ceil_w), .below_i(below_w),
    .setpoint_o(setpoint), .skip_o(pfm_skip)
  );

endmodule

// File: rtl/ssp_checker.sv
module ssp_checker #(
  parameter int unsigned SET_W       = 8,
  parameter int unsigned FLOOR_LIMIT = 40,
  parameter int unsigned FULL_LIMIT  = 240
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ss_req,
  input logic             cycle_start,
  input logic [SET_W-1:0] setpoint,
  input logic             pfm_skip,
  input logic             ss_active,
  input logic [SET_W-1:0] ceil_q
);

  // R8: setpoint changes only on a cycle-start edge
  p_hold_between_starts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cycle_start |=> $stable(setpoint));

  // R8: captured setpoint never exceeds the ceiling that was in force
  p_capped_by_ceiling_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start |=> (setpoint <= $past(ceil_q)));

  // R6: never above the full limit
  p_within_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    setpoint <= SET_W'(FULL_LIMIT));

  // R9: a skipped cycle carries at most the floor current
  p_skip_at_floor_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pfm_skip |-> (setpoint <= SET_W'(FLOOR_LIMIT)));

  // R3: a restart request zeroes the ceiling and reopens soft-start
  p_restart_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ss_req |=> (ss_active && ceil_q == '0));

  // R4: once finished, soft-start stays finished until requested again
  p_done_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ss_active && !ss_req) |=> !ss_active);

endmodule

bind soft_start_pfm_setpoint ssp_checker #(
  .SET_W(SET_W), .FLOOR_LIMIT(FLOOR_LIMIT), .FULL_LIMIT(FULL_LIMIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ss_req(ss_req), .cycle_start(cycle_start),
  .setpoint(setpoint), .pfm_skip(pfm_skip), .ss_active(ss_active),
  .ceil_q(ceil_w)
);

// File: tb/soft_start_pfm_setpoint_test.sv
`timescale 1ns/1ps
module soft_start_pfm_setpoint_test;
  localparam int CW  = 8;
  localparam int SW  = 8;
  localparam int FLR = 48;
  localparam int FUL = 200;
  localparam int TL  = 64;
  localparam int TH  = 192;
  localparam int NS  = 8;
  localparam int ST  = 20;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ss_req;
  logic          cycle_start;
  logic [CW-1:0] ctrl_code;
  logic [SW-1:0] setpoint;
  logic          pfm_skip;
  logic          ss_active;

  int errors = 0;
  int checks = 0;
  int elapsed = 0;
  int exp_sp = 0;
  bit exp_skip = 0;

  always #2.5 clk = ~clk;

  soft_start_pfm_setpoint #(
    .CODE_W(CW), .SET_W(SW), .FLOOR_LIMIT(FLR), .FULL_LIMIT(FUL),
    .PFM_CODE(TL), .FULL_CODE(TH), .SS_STEPS(NS), .STEP_TICKS(ST)
  ) uut (
    .clk(clk), .rst_n(rst_n), .ss_req(ss_req), .cycle_start(cycle_start),
    .ctrl_code(ctrl_code), .setpoint(setpoint), .pfm_skip(pfm_skip),
    .ss_active(ss_active)
  );

  function automatic int map_code(int c);
    if (c <= TL) return FLR;
    if (c >= TH) return FUL;
    return FLR + ((c - TL) * (FUL - FLR)) / (TH - TL);
  endfunction

  function automatic int step_of(int e);
    int k = e / ST;
    return (k > NS) ? NS : k;
  endfunction

  function automatic int ceil_of(int e);
    return (FUL * step_of(e)) / NS;
  endfunction

  function automatic string region_tag(int c);
    if (c <= TL) return "R5";
    if (c >= TH) return "R6";
    return "R7";
  endfunction

  task automatic check(string tag, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // called at a falling edge: drive, model the next rising edge, check at the following falling edge
  task automatic cyc(bit ss, bit cs, int code, string sp_tag);
    string t;
    ss_req      = ss;
    cycle_start = cs;
    ctrl_code   = CW'(code);
    if (cs) begin
      exp_sp   = (map_code(code) < ceil_of(elapsed)) ? map_code(code) : ceil_of(elapsed);
      exp_skip = (code < TL);
    end
    elapsed = ss ? 0 : elapsed + 1;
    @(negedge clk);
    t = (sp_tag != "") ? sp_tag : (cs ? region_tag(code) : "R8");
    check(t, "setpoint", int'(setpoint), exp_sp);
    check("R9", "pfm_skip", int'(pfm_skip), int'(exp_skip));
    check("R4", "ss_active", int'(ss_active), int'(step_of(elapsed) < NS));
  endtask

  initial begin
    #(5.0 * 190000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed = 7321;
    void'($urandom(seed));
    rst_n = 1'b0; ss_req = 1'b0; cycle_start = 1'b0; ctrl_code = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "setpoint", int'(setpoint), 0);
    check("R1", "pfm_skip", int'(pfm_skip), 0);
    check("R1", "ss_active", int'(ss_active), 1);
    rst_n = 1'b1;
    elapsed = 0; exp_sp = 0; exp_skip = 0;

    // R2: full ramp with demand at maximum, captured every cycle
    for (int i = 0; i < NS * ST + 6; i++) cyc(1'b0, 1'b1, 255, "R2");
    // R3: restart mid ramp after advancing a few steps
    cyc(1'b1, 1'b0, 255, "");
    for (int i = 0; i < 3 * ST + 5; i++) cyc(1'b0, (i % 4) == 0, 255, "R3");
    cyc(1'b1, 1'b1, 255, "R3");
    cyc(1'b0, 1'b1, 255, "R3");
    // let the ramp finish
    for (int i = 0; i < NS * ST + 2; i++) cyc(1'b0, 1'b0, 0, "");

    // directed corner codes with full ceiling
    cyc(1'b0, 1'b1, TL, "R5");
    cyc(1'b0, 1'b1, TL - 1, "R5");
    cyc(1'b0, 1'b0, 250, "R8");
    cyc(1'b0, 1'b0, 130, "R8");
    cyc(1'b0, 1'b1, 0, "R5");
    cyc(1'b0, 1'b1, TL + 1, "R7");
    cyc(1'b0, 1'b1, TH - 1, "R7");
    cyc(1'b0, 1'b1, TH, "R6");
    cyc(1'b0, 1'b1, 255, "R6");
    cyc(1'b0, 1'b1, TL - 1, "R9");
    cyc(1'b0, 1'b1, TL, "R9");

    // random traffic with rare restarts
    for (int i = 0; i < 5000; i++) begin
      bit ss = ($urandom % 400) == 0;
      bit cs = ($urandom % 3) == 0;
      int code;
      case ($urandom % 6)
        0:       code = TL - 1 + int'($urandom % 3);
        1:       code = TH - 1 + int'($urandom % 3);
        default: code = int'($urandom % 256);
      endcase
      cyc(ss, cs, code, "");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule